// File: doc/BRIEF.md
# Branch Resolve and Next-PC Stage

This stage works out where a program goes after a jump-class or narrow-jump-class instruction. The program counter counts 64-bit instruction slots. Each cycle that `in_valid` is high, the stage takes in the following:

- the current PC and the slot count of the current instruction;
- the four-bit operation code and the source-select bit;
- the source register field;
- the 16-bit offset and the 32-bit immediate;
- the values of both register operands.

One cycle later it presents these results:

- the next PC;
- a taken flag;
- one-hot request flags for a local call, a helper call, a function return or an illegal encoding.

A sequencer outside the stage acts on the request flags. The stage does not stack return addresses or dispatch helper functions. It does not decode wide instructions either: the caller tells it the width of the current instruction through `pc_step`.

The class select `narrow` picks the operand width. When it is 0, comparisons use the full 64 bits. When it is 1, they use only the low 32 bits. A branch that is taken lands relative to the instruction that follows it, so its target is `pc + pc_step + displacement`.

Top module: `br_next_pc`

## Requirements
- R1: Outputs are registered. `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. Reset clears `out_valid`, `next_pc`, `taken` and every request flag to 0.
- R2: When a result is not taken, `next_pc = pc + pc_step`, modulo 2^PC_W.
- R3: When a result is taken, `next_pc = pc + pc_step + disp`. Conditional branches use the sign-extended 16-bit `br_off` as `disp`. The target wraps modulo 2^PC_W.
- R4: Code 0x0 is an unconditional jump that is always taken. With `narrow=0`, `disp` is `br_off`. With `narrow=1`, `disp` is the sign-extended 32-bit `imm`, and `br_off` is ignored.
- R5: Unsigned compares are code 0x2 (dst > src), 0x3 (dst >= src), 0xa (dst < src) and 0xb (dst <= src).
- R6: Signed compares are code 0x6 (>), 0x7 (>=), 0xc (<) and 0xd (<=).
- R7: Code 0x1 is taken when the operands are equal. Code 0x5 is taken when they differ. Code 0x4 is taken when dst AND src is nonzero.
- R8: The source operand is `src_val` when `src_is_reg=1`, and otherwise it is `imm` sign-extended to 64 bits. With `narrow=0`, compares use all 64 bits. With `narrow=1`, they use only bits [31:0], read as unsigned or as signed 32-bit values.
- R9: Code 0x8 with `src_sel=1` raises `call_local`, is taken, and targets `pc + pc_step + sext(imm)`.
- R10: Code 0x8 with `src_sel` 0 or 2 raises `call_helper`, is not taken, and falls through.
- R11: Code 0x9 with `src_sel=0` raises `exit_req`, is not taken, and falls through.
- R12: The following cases raise `illegal`:
  - code 0xe or 0xf;
  - `src_is_reg=1` with code 0x0, 0x8 or 0x9;
  - code 0x8 or 0x9 with `narrow=1`;
  - code 0x8 with `src_sel` above 2;
  - code 0x0 or 0x9 with a nonzero `src_sel`;
  - `pc_step` other than 1 or 2.

  When `illegal` is high, `taken` and the other request flags are 0 and `next_pc = pc + pc_step`.
- R13: At most one of `call_local`, `call_helper`, `exit_req` and `illegal` is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present this cycle |
| pc | input | PC_W | Current PC in 64-bit slots |
| pc_step | input | 2 | Slot count of the current instruction (1 or 2) |
| narrow | input | 1 | 1 = 32-bit operand class, 0 = 64-bit class |
| op_code | input | 4 | Operation code |
| src_is_reg | input | 1 | 1 = register source, 0 = immediate source |
| src_sel | input | 4 | Source register field |
| br_off | input | 16 | Signed offset field |
| imm | input | 32 | Signed immediate field |
| dst_val | input | 64 | Destination register value |
| src_val | input | 64 | Source register value |
| out_valid | output | 1 | Result present |
| next_pc | output | PC_W | Next program counter |
| taken | output | 1 | Control leaves the fall-through path |
| call_local | output | 1 | Local call request |
| call_helper | output | 1 | Helper call request |
| exit_req | output | 1 | Return request |
| illegal | output | 1 | Invalid encoding |

## Verification
The bench targets these corner cases:
- An all-ones operand, which is greater than 1 as unsigned but less than 1 as signed. A design that mixed up the signedness of compares would branch the wrong way on it.
- Operands whose upper halves differ while their low halves match. In the narrow class these must compare equal; a width-select bug shows up as a wrong equality or sign decision.
- Negative displacements, a two-slot `pc_step` and PC wrap-around. These expose a target taken from the branch itself instead of from the next instruction, and a missing sign extension.
- Every illegal combination. A design that lets any of them branch, or raise a call or exit flag, fails these checks.

// File: rtl/br_next_pc.sv
module br_next_pc #(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [PC_W-1:0] pc,
  input  logic [1:0]      pc_step,
  input  logic            narrow,
  input  logic [3:0]      op_code,
  input  logic            src_is_reg,
  input  logic [3:0]      src_sel,
  input  logic [15:0]     br_off,
  input  logic [31:0]     imm,
  input  logic [63:0]     dst_val,
  input  logic [63:0]     src_val,
  output logic            out_valid,
  output logic [PC_W-1:0] next_pc,
  output logic            taken,
  output logic            call_local,
  output logic            call_helper,
  output logic            exit_req,
  output logic            illegal
);

  logic [63:0] imm_x, src_raw, ua, ub, sa, sb;
  logic        eq, ugt, ult, sgt, slt, any_set;

  assign imm_x   = {{32{imm[31]}}, imm};
  assign src_raw = src_is_reg ? src_val : imm_x;
  assign ua = narrow ? {32'b0, dst_val[31:0]} : dst_val;
  assign ub = narrow ? {32'b0, src_raw[31:0]} : src_raw;
  assign sa = narrow ? {{32{dst_val[31]}}, dst_val[31:0]} : dst_val;
  assign sb = narrow ? {{32{src_raw[31]}}, src_raw[31:0]} : src_raw;

  assign eq      = ua == ub;
  assign ugt     = ua > ub;
  assign ult     = ua < ub;
  assign sgt     = $signed(sa) > $signed(sb);
  assign slt     = $signed(sa) < $signed(sb);
  assign any_set = |(ua & ub);

  logic            take, bad, want_local, want_helper, want_exit, use_imm;
  logic            step_ok, ill_n;
  logic [PC_W-1:0] fall, disp, target;

  always_comb begin
    take        = 1'b0;
    bad         = 1'b0;
    want_local  = 1'b0;
    want_helper = 1'b0;
    want_exit   = 1'b0;
    use_imm     = 1'b0;
    case (op_code)
      4'h0: begin
        bad     = src_is_reg || (src_sel != 4'd0);
        take    = 1'b1;
        use_imm = narrow;
      end
      4'h1: take = eq;
      4'h2: take = ugt;
      4'h3: take = ugt || eq;
      4'h4: take = any_set;
      4'h5: take = !eq;
      4'h6: take = sgt;
      4'h7: take = !slt;
      4'h8: begin
        bad         = narrow || src_is_reg || (src_sel > 4'd2);
        want_local  = (src_sel == 4'd1);
        want_helper = (src_sel == 4'd0) || (src_sel == 4'd2);
        take        = want_local;
        use_imm     = 1'b1;
      end
      4'h9: begin
        bad       = narrow || src_is_reg || (src_sel != 4'd0);
        want_exit = 1'b1;
      end
      4'ha: take = ult;
      4'hb: take = ult || eq;
      4'hc: take = slt;
      4'hd: take = !sgt;
      default: bad = 1'b1;
    endcase
  end

  assign step_ok = (pc_step == 2'd1) || (pc_step == 2'd2);
  assign ill_n   = !bad && step_ok;
  assign fall    = pc + PC_W'(pc_step);
  assign disp    = use_imm ? PC_W'($signed(imm)) : PC_W'($signed(br_off));
  assign target  = fall + disp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      next_pc     <= '0;
      taken       <= 1'b0;
      call_local  <= 1'b0;
      call_helper <= 1'b0;
      exit_req    <= 1'b0;
      illegal     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        taken       <= ill_n && take;
        next_pc     <= (ill_n && take) ? target : fall;
        call_local  <= ill_n && want_local;
        call_helper <= ill_n && want_helper;
        exit_req    <= ill_n && want_exit;
        illegal     <= !ill_n;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R1
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R1
  AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid ##1 !taken |-> next_pc == $past(pc) + PC_W'($past(pc_step))); // R2
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !taken); // R12
  AST_LOCAL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    call_local |-> taken); // R9
  AST_EXIT_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (exit_req || call_helper) |-> !taken); // R11
  AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({call_local, call_helper, exit_req, illegal})); // R13

endmodule

// File: tb/br_next_pc_test.sv
module br_next_pc_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] pc = '0;
  logic [1:0]  pc_step = 2'd1;
  logic        narrow = 1'b0;
  logic [3:0]  op_code = '0;
  logic        src_is_reg = 1'b0;
  logic [3:0]  src_sel = '0;
  logic [15:0] br_off = '0;
  logic [31:0] imm = '0;
  logic [63:0] dst_val = '0;
  logic [63:0] src_val = '0;
  logic        out_valid, taken, call_local, call_helper, exit_req, illegal;
  logic [31:0] next_pc;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  br_next_pc #(.PC_W(32)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pc(pc), .pc_step(pc_step),
    .narrow(narrow), .op_code(op_code), .src_is_reg(src_is_reg), .src_sel(src_sel),
    .br_off(br_off), .imm(imm), .dst_val(dst_val), .src_val(src_val),
    .out_valid(out_valid), .next_pc(next_pc), .taken(taken), .call_local(call_local),
    .call_helper(call_helper), .exit_req(exit_req), .illegal(illegal)
  );

  task automatic check(string req, logic exp_tk, logic [31:0] exp_pc, logic [3:0] exp_fl);
    logic [3:0] fl;
    fl = {call_local, call_helper, exit_req, illegal};
    checks++;
    if (!out_valid || taken !== exp_tk || next_pc !== exp_pc || fl !== exp_fl) begin
      fails++;
      $display("FAIL %s: got v=%b tk=%b pc=%0d fl=%b, expected v=1 tk=%b pc=%0d fl=%b",
               req, out_valid, taken, next_pc, fl, exp_tk, exp_pc, exp_fl);
    end
  endtask

  task automatic issue(logic n, logic [3:0] code, logic sreg, logic [3:0] ssel,
                       logic [15:0] off, logic [31:0] im, logic [63:0] d, logic [63:0] s,
                       logic [31:0] p, logic [1:0] st);
    @(negedge clk);
    narrow = n; op_code = code; src_is_reg = sreg; src_sel = ssel; br_off = off;
    imm = im; dst_val = d; src_val = s; pc = p; pc_step = st; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    checks++;
    if (out_valid || taken || next_pc != 0 || call_local || call_helper || exit_req || illegal) begin
      fails++;
      $display("FAIL R1 reset: got v=%b tk=%b pc=%0d, expected all zero", out_valid, taken, next_pc);
    end
  endtask

  task automatic t_idle;
    issue(0, 4'h1, 1, 0, 16'd4, 0, 64'd3, 64'd3, 32'd100, 2'd1);
    @(negedge clk);
    checks++;
    if (out_valid) begin
      fails++;
      $display("FAIL R1 idle: got out_valid=1, expected 0");
    end
  endtask

  task automatic t_equality;
    issue(0, 4'h1, 1, 0, 16'd4, 0, 64'd5, 64'd6, 32'd100, 2'd1); check("R2 jeq miss", 0, 101, 0);
    issue(0, 4'h1, 1, 0, -16'sd3, 0, 64'd7, 64'd7, 32'd100, 2'd1); check("R3 R7 jeq back", 1, 98, 0);
    issue(0, 4'h5, 1, 0, 16'd10, 0, 64'd7, 64'd8, 32'd100, 2'd1); check("R7 jne", 1, 111, 0);
    issue(0, 4'h4, 1, 0, 16'd10, 0, 64'hF0, 64'h0F, 32'd100, 2'd1); check("R7 jset clear", 0, 101, 0);
    issue(0, 4'h4, 1, 0, 16'd10, 0, 64'hF0, 64'h10, 32'd100, 2'd1); check("R7 jset hit", 1, 111, 0);
    issue(0, 4'h1, 1, 0, 16'd4, 0, 64'd1, 64'd1, 32'd100, 2'd2); check("R3 step2", 1, 106, 0);
    issue(0, 4'h1, 1, 0, -16'sd2, 0, 64'd1, 64'd1, 32'd0, 2'd1); check("R3 wrap", 1, 32'hFFFF_FFFF, 0);
  endtask

  task automatic t_unsigned;
    issue(0, 4'h2, 1, 0, 16'd5, 0, '1, 64'd1, 32'd100, 2'd1); check("R5 jgt", 1, 106, 0);
    issue(0, 4'ha, 1, 0, 16'd5, 0, '1, 64'd1, 32'd100, 2'd1); check("R5 jlt", 0, 101, 0);
    issue(0, 4'h3, 1, 0, 16'd5, 0, 64'd9, 64'd9, 32'd100, 2'd1); check("R5 jge eq", 1, 106, 0);
    issue(0, 4'hb, 1, 0, 16'd5, 0, 64'd2, 64'd1, 32'd100, 2'd1); check("R5 jle", 0, 101, 0);
  endtask

  task automatic t_signed;
    issue(0, 4'h6, 1, 0, 16'd5, 0, '1, 64'd1, 32'd100, 2'd1); check("R6 jsgt", 0, 101, 0);
    issue(0, 4'hc, 1, 0, 16'd5, 0, '1, 64'd1, 32'd100, 2'd1); check("R6 jslt", 1, 106, 0);
    issue(0, 4'h7, 1, 0, 16'd5, 0, '1, '1, 32'd100, 2'd1); check("R6 jsge eq", 1, 106, 0);
    issue(0, 4'hd, 1, 0, 16'd5, 0, 64'd1, '1, 32'd100, 2'd1); check("R6 jsle", 0, 101, 0);
  endtask

  task automatic t_width;
    issue(1, 4'h1, 1, 0, 16'd5, 0, 64'h1_0000_0005, 64'd5, 32'd100, 2'd1); check("R8 narrow eq", 1, 106, 0);
    issue(0, 4'h1, 1, 0, 16'd5, 0, 64'h1_0000_0005, 64'd5, 32'd100, 2'd1); check("R8 wide ne", 0, 101, 0);
    issue(0, 4'h1, 0, 0, 16'd5, 32'hFFFF_FFFF, '1, 0, 32'd100, 2'd1); check("R8 imm sext", 1, 106, 0);
    issue(0, 4'h1, 0, 0, 16'd5, 32'hFFFF_FFFF, 64'hFFFF_FFFF, 0, 32'd100, 2'd1); check("R8 wide imm", 0, 101, 0);
    issue(1, 4'h1, 0, 0, 16'd5, 32'hFFFF_FFFF, 64'hFFFF_FFFF, 0, 32'd100, 2'd1); check("R8 narrow imm", 1, 106, 0);
    issue(1, 4'hc, 0, 0, 16'd5, 0, 64'h8000_0000, 0, 32'd100, 2'd1); check("R8 narrow slt", 1, 106, 0);
    issue(0, 4'hc, 0, 0, 16'd5, 0, 64'h8000_0000, 0, 32'd100, 2'd1); check("R8 wide slt", 0, 101, 0);
  endtask

  task automatic t_jump;
    issue(0, 4'h0, 0, 0, 16'd5, 32'd77, 0, 0, 32'd100, 2'd1); check("R4 ja off", 1, 106, 0);
    issue(1, 4'h0, 0, 0, 16'd7, -32'sd50, 0, 0, 32'd100, 2'd1); check("R4 ja imm", 1, 51, 0);
  endtask

  task automatic t_calls;
    issue(0, 4'h8, 0, 1, 16'd3, 32'd20, 0, 0, 32'd100, 2'd1); check("R9 local", 1, 121, 4'b1000);
    issue(0, 4'h8, 0, 2, 16'd3, 32'd9, 0, 0, 32'd100, 2'd1); check("R10 helper2", 0, 101, 4'b0100);
    issue(0, 4'h8, 0, 0, 16'd3, 32'd9, 0, 0, 32'd100, 2'd1); check("R10 helper0", 0, 101, 4'b0100);
    issue(0, 4'h9, 0, 0, 16'd3, 0, 0, 0, 32'd100, 2'd1); check("R11 exit", 0, 101, 4'b0010);
  endtask

  task automatic t_illegal;
    issue(0, 4'he, 1, 0, 16'd3, 0, 0, 0, 32'd100, 2'd1); check("R12 code e", 0, 101, 4'b0001);
    issue(0, 4'hf, 0, 0, 16'd3, 0, 0, 0, 32'd100, 2'd1); check("R12 code f", 0, 101, 4'b0001);
    issue(0, 4'h0, 1, 0, 16'd3, 0, 0, 0, 32'd100, 2'd1); check("R12 ja reg", 0, 101, 4'b0001);
    issue(0, 4'h0, 0, 3, 16'd3, 0, 0, 0, 32'd100, 2'd1); check("R12 ja ssel", 0, 101, 4'b0001);
    issue(1, 4'h8, 0, 1, 16'd3, 32'd20, 0, 0, 32'd100, 2'd1); check("R12 call narrow", 0, 101, 4'b0001);
    issue(0, 4'h8, 0, 3, 16'd3, 32'd20, 0, 0, 32'd100, 2'd1); check("R12 call ssel", 0, 101, 4'b0001);
    issue(0, 4'h8, 1, 1, 16'd3, 32'd20, 0, 0, 32'd100, 2'd1); check("R12 call reg", 0, 101, 4'b0001);
    issue(1, 4'h9, 0, 0, 16'd3, 0, 0, 0, 32'd100, 2'd1); check("R12 exit narrow", 0, 101, 4'b0001);
    issue(0, 4'h9, 0, 1, 16'd3, 0, 0, 0, 32'd100, 2'd1); check("R12 exit ssel", 0, 101, 4'b0001);
    issue(0, 4'h1, 1, 0, 16'd3, 0, 64'd1, 64'd1, 32'd100, 2'd0); check("R12 step0", 0, 100, 4'b0001);
    issue(0, 4'h1, 1, 0, 16'd3, 0, 64'd1, 64'd1, 32'd100, 2'd3); check("R12 step3", 0, 103, 4'b0001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_idle();
    t_equality();
    t_unsigned();
    t_signed();
    t_width();
    t_jump();
    t_calls();
    t_illegal();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule